// File: doc/BRIEF.md
# Flash Byte Program-Verify Sequencer

This block writes one byte into a command-driven flash array. A flash cell can only move from one to zero, so the byte is written with a loop of pulses, each checked by reading the cell back. When a request arrives the block takes the address and the byte and reads the location first. If the request needs any bit to go from zero back to one, it is rejected with an error and the supply stays off.

Otherwise the block switches on the programming supply and waits for it to settle. It then loops: it writes the program command, writes the data byte (which starts one pulse), waits the pulse time, writes the verify command, waits, reads back and compares. A match ends the loop. A mismatch starts another pulse, up to a bound. The block then switches the supply off, waits for it to settle again and reports done or fail. The number of pulses used stays on a status output for wear monitoring.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Out of reset, `busy_o`, `vpp_en_o`, `fl_wr_o`, `fl_rd_o`, `done_o`, `fail_o` and `err_o` are all low.
- R2: A request is accepted only when idle. `busy_o` is high from the cycle after acceptance through the cycle of the single result pulse, and is low after it. A request made while busy has no effect: no access goes to its address and no second result follows.
- R3: Before any pulse, the target location is read once. If any bit is 0 in the stored byte and 1 in the requested byte, `err_o` pulses and `pulses_o` is 0. In that case the supply never turns on and no write goes to the flash.
- R4: After the supply turns on, `vpp_en_o` stays high for exactly `SETTLE_CYC` cycles before the first flash write.
- R5: Each pulse is two writes to the target address: first `CMD_PROG` on `fl_wdata_o`, then the data byte. Every pulse is counted. No flash write happens while the supply is off.
- R6: Exactly `PULSE_CYC` idle cycles separate the data write from the following write of `CMD_VFY`.
- R7: Exactly `VFY_CYC` idle cycles separate the verify command from the read. Read data (`fl_rdata_i`) is taken in the cycle after `fl_rd_o`. A read equal to the byte ends the loop with `done_o`.
- R8: On a mismatch a new pulse is issued. After `MAX_PULSES` pulses without a match, `fail_o` pulses and `pulses_o` equals `MAX_PULSES`.
- R9: After the loop ends, the supply is off for exactly `SETTLE_CYC` cycles before `done_o` or `fail_o`.
- R10: `pulses_o` holds the pulse count of the last operation until the next request is accepted.
- R11: A cell that takes the byte on its first pulse finishes with `done_o` and `pulses_o` equal to 1. That operation makes exactly three flash writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| addr_i | input | AW | Target address |
| data_i | input | DW | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: byte verified |
| fail_o | output | 1 | One-cycle pulse: pulse bound reached |
| err_o | output | 1 | One-cycle pulse: request needs a zero-to-one change |
| pulses_o | output | $clog2(MAX_PULSES+1) | Pulses used by the last operation |
| vpp_en_o | output | 1 | Programming supply enable |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | DW | Flash write data: command or byte |
| fl_rdata_i | input | DW | Flash read data, valid the cycle after `fl_rd_o` |

## Verification
The bench builds the block with a 4-bit address and short timings: `SETTLE_CYC`=5, `PULSE_CYC`=3 and `VFY_CYC`=2. `MAX_PULSES` stays at 25. With these values the settle windows and the inter-command gaps can be counted one cycle at a time. A full run to the 25-pulse bound, and a cell that takes exactly 25 pulses, both finish within a few hundred cycles. A flash model with a configurable pulse count for each cell covers three cases: one-pulse success, several retries, and cells that never take the byte.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PRE_CHK, S_ON_WAIT, S_PROG_CMD, S_PROG_DAT,
    S_PULSE_WAIT, S_VFY_CMD, S_VFY_WAIT, S_VFY_RD, S_VFY_CHK,
    S_OFF_WAIT, S_REPORT
  } seq_state_e;

  typedef enum logic [1:0] {RES_OK, RES_FAIL, RES_ERR} result_e;
endpackage

// File: rtl/fpc_timer.sv
module fpc_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/fpc_pulse_ctr.sv
module fpc_pulse_ctr #(
  parameter int MAX_PULSES = 25,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i && !at_max_o) cnt_o <= cnt_o + 1'b1;
  end

  assign at_max_o = (cnt_o == CW'(MAX_PULSES));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int MAX_PULSES = 25,
  parameter int PULSE_CYC  = 500,
  parameter int VFY_CYC    = 300,
  parameter int SETTLE_CYC = 2_500_000,
  parameter logic [DW-1:0] CMD_PROG = DW'(8'h5A),
  parameter logic [DW-1:0] CMD_VFY  = DW'(8'hA6),
  localparam int CW   = $clog2(MAX_PULSES + 1),
  localparam int TMAX = (SETTLE_CYC > PULSE_CYC)
                        ? ((SETTLE_CYC > VFY_CYC) ? SETTLE_CYC : VFY_CYC)
                        : ((PULSE_CYC > VFY_CYC) ? PULSE_CYC : VFY_CYC),
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          err_o,
  output logic [CW-1:0] pulses_o,
  output logic          vpp_en_o,
  output logic          fl_wr_o,
  output logic          fl_rd_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [DW-1:0] fl_rdata_i
);
  seq_state_e    state_q, state_d;
  result_e       res_q, res_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] tmr_lim;
  logic          tmr_exp, at_max, accept;

  assign accept = (state_q == S_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (accept) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      S_IDLE:       if (req_i) state_d = S_PRE_RD;
      S_PRE_RD:     state_d = S_PRE_CHK;
      S_PRE_CHK:
        if ((~fl_rdata_i & data_q) != '0) begin
          res_d   = RES_ERR;
          state_d = S_REPORT;
        end else begin
          state_d = S_ON_WAIT;
        end
      S_ON_WAIT:    if (tmr_exp) state_d = S_PROG_CMD;
      S_PROG_CMD:   state_d = S_PROG_DAT;
      S_PROG_DAT:   state_d = S_PULSE_WAIT;
      S_PULSE_WAIT: if (tmr_exp) state_d = S_VFY_CMD;
      S_VFY_CMD:    state_d = S_VFY_WAIT;
      S_VFY_WAIT:   if (tmr_exp) state_d = S_VFY_RD;
      S_VFY_RD:     state_d = S_VFY_CHK;
      S_VFY_CHK:
        if (fl_rdata_i == data_q) begin
          res_d   = RES_OK;
          state_d = S_OFF_WAIT;
        end else if (at_max) begin
          res_d   = RES_FAIL;
          state_d = S_OFF_WAIT;
        end else begin
          state_d = S_PROG_CMD;
        end
      S_OFF_WAIT:   if (tmr_exp) state_d = S_REPORT;
      S_REPORT:     state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_PULSE_WAIT: tmr_lim = TW'(PULSE_CYC);
      S_VFY_WAIT:   tmr_lim = TW'(VFY_CYC);
      default:      tmr_lim = TW'(SETTLE_CYC);
    endcase
  end

  fpc_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_d != state_q),
    .lim_i     (tmr_lim),
    .expired_o (tmr_exp)
  );

  fpc_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .inc_i    (state_q == S_PROG_DAT),
    .cnt_o    (pulses_o),
    .at_max_o (at_max)
  );

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_REPORT) && (res_q == RES_OK);
  assign fail_o   = (state_q == S_REPORT) && (res_q == RES_FAIL);
  assign err_o    = (state_q == S_REPORT) && (res_q == RES_ERR);
  assign vpp_en_o = (state_q inside {S_ON_WAIT, S_PROG_CMD, S_PROG_DAT, S_PULSE_WAIT,
                                     S_VFY_CMD, S_VFY_WAIT, S_VFY_RD, S_VFY_CHK});
  assign fl_wr_o  = (state_q inside {S_PROG_CMD, S_PROG_DAT, S_VFY_CMD});
  assign fl_rd_o  = (state_q inside {S_PRE_RD, S_VFY_RD});
  assign fl_addr_o = addr_q;

  always_comb begin
    unique case (state_q)
      S_PROG_CMD: fl_wdata_o = CMD_PROG;
      S_PROG_DAT: fl_wdata_o = data_q;
      S_VFY_CMD:  fl_wdata_o = CMD_VFY;
      default:    fl_wdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int MAX_PULSES = 25,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          err_o,
  input logic          vpp_en_o,
  input logic          fl_wr_o,
  input logic          fl_rd_o,
  input logic [CW-1:0] pulses_o
);
  logic any_res;
  assign any_res = done_o | fail_o | err_o;

  AST_SUPPLY_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !vpp_en_o); // R1
  AST_WR_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_o |-> vpp_en_o); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_wr_o && fl_rd_o)); // R5
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, err_o})); // R2
  AST_RESULT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_res |=> !busy_o); // R2
  AST_RESULT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_res |-> busy_o); // R2
  AST_RESULT_SUPPLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_res |-> !vpp_en_o); // R9
  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_o <= CW'(MAX_PULSES)); // R8
  AST_FAIL_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> pulses_o == CW'(MAX_PULSES)); // R8
  AST_ERR_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> pulses_o == '0); // R3
  AST_DONE_HAS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pulses_o != '0); // R11
  AST_PULSES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(pulses_o)); // R10
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fail_o   (fail_o),
  .err_o    (err_o),
  .vpp_en_o (vpp_en_o),
  .fl_wr_o  (fl_wr_o),
  .fl_rd_o  (fl_rd_o),
  .pulses_o (pulses_o)
);

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;
  localparam int AW = 4, DW = 8, MAXP = 25;
  localparam int PULSE = 3, VFY = 2, SETTLE = 5;
  localparam logic [7:0] CPROG = 8'h5A, CVFY = 8'hA6;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, done, fail, err, vpp, fl_wr, fl_rd;
  logic [CW-1:0] pulses;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata = '0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .DW(DW), .MAX_PULSES(MAXP), .PULSE_CYC(PULSE),
    .VFY_CYC(VFY), .SETTLE_CYC(SETTLE), .CMD_PROG(CPROG), .CMD_VFY(CVFY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .data_i(data),
    .busy_o(busy), .done_o(done), .fail_o(fail), .err_o(err), .pulses_o(pulses),
    .vpp_en_o(vpp), .fl_wr_o(fl_wr), .fl_rd_o(fl_rd), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata));

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] mem [16];
  int need [16];
  int pcnt [16];

  // per-operation monitor state
  int on_cnt, off_cnt, wr_cnt, res_cnt, res_kind, pgap, vgap;
  bit seen_wr, vpp_seen, armed, pgap_on, vgap_on;
  logic [AW-1:0] cur_addr;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (fl_rd) begin
        if (vgap_on) begin chk(vgap == VFY, "R7 verify gap", vgap, VFY); vgap_on = 1'b0; end
        fl_rdata = mem[fl_addr];
      end
      if (fl_wr) begin
        wr_cnt++;
        chk(fl_addr == cur_addr, "R5 write address", int'(fl_addr), int'(cur_addr));
        if (!seen_wr) begin
          chk(on_cnt == SETTLE, "R4 settle on", on_cnt, SETTLE);
          seen_wr = 1'b1;
        end
        if (armed) begin
          pcnt[fl_addr]++;
          if (pcnt[fl_addr] >= need[fl_addr]) mem[fl_addr] = mem[fl_addr] & fl_wdata;
          armed = 1'b0; pgap = 0; pgap_on = 1'b1;
        end else if (fl_wdata == CPROG) begin
          armed = 1'b1;
        end else if (fl_wdata == CVFY) begin
          if (pgap_on) chk(pgap == PULSE, "R6 pulse gap", pgap, PULSE);
          pgap_on = 1'b0; vgap = 0; vgap_on = 1'b1;
        end else begin
          chk(1'b0, "R5 unexpected write", int'(fl_wdata), int'(CPROG));
        end
      end
      if (!fl_wr && !fl_rd) begin
        if (pgap_on) pgap++;
        if (vgap_on) vgap++;
      end
      if (vpp) vpp_seen = 1'b1;
      if (vpp && !seen_wr && !fl_wr) on_cnt++;
      if (done || fail || err) begin
        res_cnt++;
        res_kind = done ? 1 : (fail ? 2 : 3);
        if (seen_wr) chk(off_cnt == SETTLE, "R9 settle off", off_cnt, SETTLE);
      end else if (busy && !vpp && seen_wr) begin
        off_cnt++;
      end
    end
  end

  // expected result: kind 1 done, 2 fail, 3 error
  function automatic int exp_kind(input logic [7:0] old, input logic [7:0] d, input int n);
    if ((~old & d) != 8'h00) return 3;
    if (old == d || n <= MAXP) return 1;
    return 2;
  endfunction

  function automatic int exp_pulses(input logic [7:0] old, input logic [7:0] d, input int n);
    int k = exp_kind(old, d, n);
    if (k == 3) return 0;
    if (k == 2) return MAXP;
    return (old == d) ? 1 : n;
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                        input bit poke, input string r);
    logic [7:0] old = mem[a];
    int ek = exp_kind(old, d, n);
    int ep = exp_pulses(old, d, n);
    logic [AW-1:0] oa = a + 1'b1;
    logic [7:0] old_o = mem[oa];
    logic [7:0] exp_mem = (ek == 1) ? (old & d) : old;
    int guard = 0;
    int held;
    need[a] = n; pcnt[a] = 0;
    on_cnt = 0; off_cnt = 0; wr_cnt = 0; res_cnt = 0; res_kind = 0;
    seen_wr = 0; vpp_seen = 0; armed = 0; pgap_on = 0; vgap_on = 0; cur_addr = a;
    req = 1'b1; addr = a; data = d;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    if (poke) begin
      @(negedge clk); @(negedge clk);
      req = 1'b1; addr = oa; data = 8'h00;
      @(negedge clk);
      req = 1'b0;
    end
    while (res_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
    chk(res_kind == ek, {r, " result kind"}, res_kind, ek);
    chk(int'(pulses) == ep, {r, " pulses"}, int'(pulses), ep);
    chk(mem[a] == exp_mem, {r, " cell content"}, int'(mem[a]), int'(exp_mem));
    if (ek == 3) begin
      chk(wr_cnt == 0, "R3 no write on error", wr_cnt, 0);
      chk(vpp_seen == 1'b0, "R3 supply stays off", int'(vpp_seen), 0);
    end else begin
      chk(wr_cnt == 3 * ep, "R5 writes per pulse", wr_cnt, 3 * ep);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R2 idle after result", int'(busy), 0);
    if (poke) begin
      held = int'(pulses);
      repeat (8) @(negedge clk);
      chk(busy == 1'b0 && res_cnt == 1, "R2 request while busy ignored", res_cnt, 1);
      chk(mem[oa] == old_o, "R2 ignored address untouched", int'(mem[oa]), int'(old_o));
      chk(int'(pulses) == held, "R10 count held", int'(pulses), held);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; need[i] = 1; pcnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !vpp && !fl_wr && !fl_rd && !done && !fail && !err, "R1 reset state",
        int'({busy, vpp, fl_wr, fl_rd, done, fail, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !vpp, "R1 idle after reset", int'({busy, vpp}), 0);

    run_op(4'd0, 8'h3C, 1, 1'b0, "R11 single pulse");
    run_op(4'd1, 8'hA5, 3, 1'b0, "R8 three pulses");
    run_op(4'd2, 8'h00, MAXP, 1'b0, "R8 bound exact");
    run_op(4'd3, 8'h12, 30, 1'b0, "R8 bound exceeded");
    run_op(4'd0, 8'h7C, 1, 1'b0, "R3 zero to one");
    run_op(4'd0, 8'h3C, 4, 1'b0, "R7 already programmed");
    run_op(4'd5, 8'h81, 2, 1'b1, "R2 busy poke");
    run_op(4'd3, 8'hF0, 1, 1'b0, "R10 after fail");

    void'($urandom(32'd1991));
    for (int t = 0; t < 40; t++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      logic [7:0] d = 8'($urandom);
      int n = ($urandom_range(0, 9) == 0) ? 27 : int'($urandom_range(1, 5));
      if ($urandom_range(0, 3) != 0) d = d & mem[a];
      run_op(a, d, n, ($urandom_range(0, 4) == 0), "R7 random");
      if (int'(cycles) > 150000) break;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 180000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 180000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule